// File: doc/BRIEF.md
# Protection Key Permission Checker

This block decides, for every memory access, whether the protection key stored in the page entry permits it. Each hardware thread owns a key-rights register that software can change at any time. Changing that register alters the rights for every page tagged with a key, without rewriting any page entry. The block returns a verdict that reports key violations separately from ordinary page-permission violations, so the fault handler can tell them apart.

A static mode pin selects one of two key semantics. In narrow mode a key is 4 bits wide. Its first control bit shuts off all data access, and execute control does not exist. In wide mode a key is 5 bits wide. Its read, write and execute controls are each independent. The check is combinational on the access inputs. Software writes are registered, so the check sees a write from the cycle after it is made.

Top module: `pkey_check`

## Requirements
- R1: After reset every rights register and every execute-block register of every thread reads zero, and every access with the page check passing is allowed.
- R2: With `mode_b`=0 the key is `acc_key[3:0]`; `acc_key[4]` has no effect on the verdict.
- R3: With `mode_b`=0, bit 2k of the selected thread's rights register blocks both data reads (`acc_type` 0 or 3) and data writes (`acc_type` 1) to key k.
- R4: With `mode_b`=0, bit 2k+1 blocks data writes to key k and leaves reads allowed.
- R5: With `mode_b`=0, instruction fetches (`acc_type` 2) are never blocked by a key. Writes to the execute-block register (`wr_sel`=1) are discarded, and that register reads zero.
- R6: With `mode_b`=0, only bits 31:0 of a rights write are stored, and bits 63:32 read zero.
- R7: With `mode_b`=1, the key is all 5 bits of `acc_key`. Bit 2k blocks only data reads to key k.
- R8: With `mode_b`=1, bit 2k+1 blocks only data writes to key k.
- R9: With `mode_b`=1, bit k of the thread's execute-block register blocks only fetches from key k. Rights bits never block a fetch.
- R10: Each thread has its own registers. The check uses the registers of `acc_thread`, a write changes only the registers of `wr_thread`, and a read returns the registers of `rd_thread`.
- R11: `acc_cause` is 0 for none, 1 for a page-permission fault and 2 for a key fault. When `page_ok`=0 the cause is 1 whatever the key bits say. On a valid access exactly one of `acc_allow` and `acc_fault` is high.
- R12: The read port is combinational. A write is visible on `rd_data` and in the check only after the next rising clock edge.
- R13: With `acc_valid`=0, `acc_allow`, `acc_fault` and `acc_cause` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_b | input | 1 | Static mode select: 0 narrow keys, 1 wide keys |
| acc_valid | input | 1 | Access present |
| acc_thread | input | TW | Thread issuing the access |
| acc_key | input | 5 | Key field from the page entry |
| acc_type | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| page_ok | input | 1 | Ordinary page permission passed |
| acc_allow | output | 1 | Access permitted |
| acc_fault | output | 1 | Access refused |
| acc_cause | output | 2 | 0 none, 1 page fault, 2 key fault |
| wr_en | input | 1 | Software register write |
| wr_sel | input | 1 | 0 rights register, 1 execute-block register |
| wr_thread | input | TW | Thread whose register is written |
| wr_data | input | 64 | Write data (execute-block uses bits 31:0) |
| rd_sel | input | 1 | 0 rights register, 1 execute-block register |
| rd_thread | input | TW | Thread whose register is read |
| rd_data | output | 64 | Read data |

## Verification
A corrupted rights bit shows up on the read port as soon as that thread is read. It also shows up as a wrong cause in the same cycle as the first access that carries the affected key and access type. For that reason the bench sweeps every thread, key, access type and page result after each register load, and reads each register back. A write that goes to the wrong thread, or that is masked the wrong way, is caught by the readback straight after the write edge. Wrong mode decoding shows up as a different verdict for keys 16 to 31, or for fetches.

// File: rtl/pkey_check.sv
module pkey_check #(
  parameter int THREADS = 4,
  localparam int TW = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int KEY_W = 5,
  localparam int NKEYS = 1 << KEY_W,
  localparam int PERM_W = 2 * NKEYS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_b,
  input  logic              acc_valid,
  input  logic [TW-1:0]     acc_thread,
  input  logic [KEY_W-1:0]  acc_key,
  input  logic [1:0]        acc_type,
  input  logic              page_ok,
  output logic              acc_allow,
  output logic              acc_fault,
  output logic [1:0]        acc_cause,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [TW-1:0]     wr_thread,
  input  logic [PERM_W-1:0] wr_data,
  input  logic              rd_sel,
  input  logic [TW-1:0]     rd_thread,
  output logic [PERM_W-1:0] rd_data
);
  localparam logic [1:0] T_WRITE = 2'd1;
  localparam logic [1:0] T_FETCH = 2'd2;
  localparam logic [1:0] C_NONE = 2'd0;
  localparam logic [1:0] C_PAGE = 2'd1;
  localparam logic [1:0] C_KEY  = 2'd2;

  logic [PERM_W-1:0] perm_q [THREADS];
  logic [NKEYS-1:0]  xd_q   [THREADS];

  logic [PERM_W-1:0] wr_mask;
  assign wr_mask = mode_b ? '1 : {{(PERM_W/2){1'b0}}, {(PERM_W/2){1'b1}}};

  always_ff @(posedge clk) begin
    for (int t = 0; t < THREADS; t++) begin
      if (!rst_n) begin
        perm_q[t] <= '0;
        xd_q[t]   <= '0;
      end else if (wr_en && wr_thread == TW'(t)) begin
        if (!wr_sel)     perm_q[t] <= wr_data & wr_mask;
        else if (mode_b) xd_q[t]   <= wr_data[NKEYS-1:0];
      end
    end
  end

  logic [KEY_W-1:0]  key;
  logic [PERM_W-1:0] cur_perm;
  logic [NKEYS-1:0]  cur_xd;
  logic              rdis, wdis, xdis, key_block;

  assign key      = mode_b ? acc_key : {1'b0, acc_key[KEY_W-2:0]};
  assign cur_perm = perm_q[acc_thread];
  assign cur_xd   = xd_q[acc_thread];
  assign rdis     = cur_perm[{key, 1'b0}];
  assign wdis     = cur_perm[{key, 1'b1}];
  assign xdis     = mode_b & cur_xd[key];

  always_comb begin
    case (acc_type)
      T_FETCH: key_block = xdis;
      T_WRITE: key_block = mode_b ? wdis : (rdis | wdis);
      default: key_block = rdis;
    endcase
  end

  assign acc_cause = !acc_valid ? C_NONE :
                     !page_ok   ? C_PAGE :
                     key_block  ? C_KEY  : C_NONE;
  assign acc_fault = acc_cause != C_NONE;
  assign acc_allow = acc_valid & ~acc_fault;

  assign rd_data = rd_sel ? {{(PERM_W-NKEYS){1'b0}}, (mode_b ? xd_q[rd_thread] : {NKEYS{1'b0}})}
                          : perm_q[rd_thread];
endmodule

module pkey_check_sva #(
  parameter int THREADS = 4,
  localparam int TW = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode_b,
  input logic          acc_valid,
  input logic [1:0]    acc_type,
  input logic          page_ok,
  input logic          acc_allow,
  input logic          acc_fault,
  input logic [1:0]    acc_cause,
  input logic          wr_en,
  input logic          wr_sel,
  input logic [TW-1:0] wr_thread,
  input logic [63:0]   wr_data,
  input logic          rd_sel,
  input logic [TW-1:0] rd_thread,
  input logic [63:0]   rd_data
);
  AST_PAGE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !page_ok |-> acc_cause == 2'd1); // R11
  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> (acc_allow != acc_fault)); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> !acc_allow && !acc_fault && acc_cause == 2'd0); // R13
  AST_FETCH_FREE_A: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && page_ok && !mode_b && acc_type == 2'd2 |-> acc_allow); // R5
  AST_UPPER_ZERO_A: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_b && !rd_sel |-> rd_data[63:32] == 32'd0); // R6
  AST_WRITE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_sel && mode_b && !rd_sel && rd_thread == wr_thread
    |=> rd_sel || rd_thread != $past(rd_thread) || rd_data == $past(wr_data)); // R12
endmodule

bind pkey_check pkey_check_sva #(.THREADS(THREADS)) i_pkey_check_sva (
  .clk(clk), .rst_n(rst_n), .mode_b(mode_b), .acc_valid(acc_valid),
  .acc_type(acc_type), .page_ok(page_ok), .acc_allow(acc_allow),
  .acc_fault(acc_fault), .acc_cause(acc_cause), .wr_en(wr_en),
  .wr_sel(wr_sel), .wr_thread(wr_thread), .wr_data(wr_data),
  .rd_sel(rd_sel), .rd_thread(rd_thread), .rd_data(rd_data)
);

// File: tb/test_pkey_check.sv
module test_pkey_check;
  localparam int THREADS = 4;
  localparam int TW = 2;

  logic clk = 0, rst_n = 0, mode_b = 0;
  logic acc_valid = 0, page_ok = 1;
  logic [TW-1:0] acc_thread = '0, wr_thread = '0, rd_thread = '0;
  logic [4:0] acc_key = '0;
  logic [1:0] acc_type = '0;
  logic acc_allow, acc_fault;
  logic [1:0] acc_cause;
  logic wr_en = 0, wr_sel = 0, rd_sel = 0;
  logic [63:0] wr_data = '0, rd_data;

  logic [63:0] m_perm [THREADS];
  logic [31:0] m_xd [THREADS];
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pkey_check #(.THREADS(THREADS)) i_pkey_check (
    .clk(clk), .rst_n(rst_n), .mode_b(mode_b), .acc_valid(acc_valid),
    .acc_thread(acc_thread), .acc_key(acc_key), .acc_type(acc_type),
    .page_ok(page_ok), .acc_allow(acc_allow), .acc_fault(acc_fault),
    .acc_cause(acc_cause), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_thread(wr_thread), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_thread(rd_thread), .rd_data(rd_data));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic mb);
    @(negedge clk);
    rst_n = 0; mode_b = mb;
    repeat (2) @(negedge clk);
    rst_n = 1;
    for (int t = 0; t < THREADS; t++) begin m_perm[t] = '0; m_xd[t] = '0; end
  endtask

  task automatic do_write(input logic sel, input int thr, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_thread = TW'(thr); wr_data = d;
    @(negedge clk);
    wr_en = 0;
    if (!sel) m_perm[thr] = mode_b ? d : {32'd0, d[31:0]};
    else if (mode_b) m_xd[thr] = d[31:0];
  endtask

  task automatic readback(input string req);
    for (int t = 0; t < THREADS; t++) begin
      rd_thread = TW'(t);
      rd_sel = 0; #1;
      chk(rd_data === m_perm[t], req, "rights readback", rd_data, m_perm[t]);
      rd_sel = 1; #1;
      chk(rd_data === {32'd0, m_xd[t]}, req, "exec readback", rd_data, {32'd0, m_xd[t]});
    end
    rd_sel = 0;
  endtask

  function automatic logic [1:0] exp_cause(input logic mb, input int t, input int k5,
                                           input int typ, input logic pok);
    int k;
    logic rd, wd, blk;
    if (!pok) return 2'd1;
    k = mb ? k5 : (k5 % 16);
    rd = m_perm[t][2*k];
    wd = m_perm[t][2*k+1];
    if (typ == 2)      blk = mb & m_xd[t][k];
    else if (typ == 1) blk = mb ? wd : (rd | wd);
    else               blk = rd;
    return blk ? 2'd2 : 2'd0;
  endfunction

  task automatic sweep(input string base);
    string req;
    logic [1:0] ec;
    for (int t = 0; t < THREADS; t++) begin
      acc_thread = TW'(t);
      acc_valid = 0; #1;
      chk(!acc_allow && !acc_fault && acc_cause == 0, "R13", "idle verdict",
          {61'd0, acc_allow, acc_cause}, 64'd0);
      acc_valid = 1;
      for (int k = 0; k < 32; k++)
        for (int ty = 0; ty < 4; ty++)
          for (int p = 0; p < 2; p++) begin
            acc_key = 5'(k); acc_type = 2'(ty); page_ok = p[0];
            #1;
            ec = exp_cause(mode_b, t, k, ty, p[0]);
            if (!p[0]) req = "R11";
            else if (!mode_b && k >= 16) req = "R2";
            else if (!mode_b) req = (ty == 2) ? "R5" : (ty == 1) ? "R4" : "R3";
            else req = (ty == 2) ? "R9" : (ty == 1) ? "R8" : "R7";
            if (base.len() != 0) req = {base, "/", req};
            chk(acc_cause === ec && acc_fault === (ec != 0) && acc_allow === (ec == 0),
                req, $sformatf("t%0d key%0d type%0d pok%0d cause", t, k, ty, p),
                {62'd0, acc_cause}, {62'd0, ec});
          end
    end
    acc_valid = 0; page_ok = 1;
  endtask

  function automatic logic [63:0] pat(input int t, input int s);
    return 64'h9E3779B97F4A7C15 * 64'(t * 7 + s + 1);
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // narrow mode
    do_reset(0);
    readback("R1");
    sweep("R1");
    do_write(0, 0, 64'hFFFF_FFFF_0000_0001);
    do_write(1, 0, 64'hFFFF_FFFF);
    readback("R10");  // R6 upper cleared, R5 exec write dropped
    chk(m_perm[1] == 0, "R10", "other thread untouched", m_perm[1], 0);
    for (int t = 0; t < THREADS; t++) begin
      do_write(0, t, pat(t, 0));
      do_write(1, t, pat(t, 9));
    end
    readback("R6");
    sweep("");
    do_write(0, 1, 64'h8000_0000);          // key 15 write block only
    do_write(0, 2, 64'h4000_0000);          // key 15 full block
    sweep("");
    // R12: write visible only after the edge
    @(negedge clk);
    rd_thread = 2'd3; rd_sel = 0;
    wr_en = 1; wr_sel = 0; wr_thread = 2'd3; wr_data = 64'h0000_0000_1234_5678;
    #1;
    chk(rd_data === m_perm[3], "R12", "before edge", rd_data, m_perm[3]);
    @(posedge clk); #1;
    wr_en = 0;
    m_perm[3] = 64'h1234_5678;
    chk(rd_data === 64'h1234_5678, "R12", "after edge", rd_data, 64'h1234_5678);

    // wide mode
    do_reset(1);
    readback("R1");
    for (int t = 0; t < THREADS; t++) begin
      do_write(0, t, pat(t, 3));
      do_write(1, t, pat(t, 5));
    end
    readback("R10");
    sweep("");
    do_write(0, 0, 64'h5555_5555_5555_5555); // all read blocks
    do_write(0, 1, 64'hAAAA_AAAA_AAAA_AAAA); // all write blocks
    do_write(1, 2, 64'hFFFF_FFFF);           // all fetch blocks
    do_write(0, 3, 64'hC000_0000_0000_0000); // key 31 only
    readback("R10");
    sweep("");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule